// File: doc/BRIEF.md
# Raster Frame-Lock and Variable-Refresh Controller

This block sits beside a raster timing generator and decides when that generator should follow an external frame-start signal. It watches an asynchronous frame-start input, the generator's current horizontal and vertical counter values, and a small set of mode and timing settings. It answers with three kinds of command. The first is a one-cycle counter-load request carrying a target position. The second is a hold level that freezes the raster. The third is a per-line length correction of plus or minus one pixel.

There are three operating modes. In free-running mode the frame-start input is ignored. In frame-lock mode the raster is expected to be at a programmed position when a frame start arrives. A hard lock reloads the counters when the event lands outside a tolerance window. A soft lock first ignores the input for some lines and then steers the raster back one pixel per line. In variable-refresh mode one setting picks the behaviour after the last active line. Either the raster stalls until the next frame start, or the generator keeps repeating whole blanking lines until one arrives.

Top module: `fl_frame_lock_ctrl`

## Requirements
- R1: The frame-start input passes through a two-stage synchronizer. With `toggle_en` low, only a rising edge is an event, and a falling edge has no effect. The first clock edge that samples `fs_in` high counts as edge one. A resulting load shows on `load_en` after edge four, for one cycle.
- R2: With `toggle_en` high, the rising edge and the falling edge of `fs_in` are each an event.
- R3: When `mode` is 2'b00 (free-running), frame-start events have no effect. The same holds for 2'b11. In these modes `load_en` stays low, `hold` stays low and `line_adj` stays 2'b00.
- R4: In lock mode (`mode` = 2'b01) the controller measures the distance of each event from the expected point. It takes the linear position `v_pos*h_total + h_pos` at the event and compares it with `v_target*h_total + h_target`. If that distance is at most `tol` cycles, no load is issued.
- R5: In lock mode with `soft_en` low, an event farther than `tol` from the expected point gives exactly one single-cycle `load_en` pulse. That pulse carries `load_h` = `h_target` and `load_v` = `v_target`.
- R6: The distance wraps around the frame, whose size is `h_total*v_total`. An event just before the frame end is therefore close to an expected point just after the frame start.
- R7: In lock mode with `soft_en` high, an out-of-window event never loads the counters. It starts a soft-lock sequence instead. During the first `ign_lines` lines after that event, further events are disregarded. A line starts in the cycle where `h_pos` becomes 0.
- R8: In a soft-lock sequence, line k after the event (k = 0 for the first line start) is an adjust line when `ign_lines` <= k < `adj_lines`. On an adjust line `line_adj` is 2'b01 (lengthen by one pixel) while the measured error is positive, meaning the raster is ahead. It is 2'b11 (shorten by one pixel) while the error is negative. Each such line moves the error one step toward zero, and `line_adj` is 2'b00 once the error is zero and on all other lines. `line_adj` changes only at a line start, and 2'b10 is never driven.
- R9: In variable-refresh mode (`mode` = 2'b10) with `vrr_line_mode` low, `hold` goes high the cycle after the raster reaches the last pixel of line `v_last`. It then stays high until a frame-start event. `hold` falls after edge four as in R1 and does not rise again while the position is unchanged.
- R10: In variable-refresh mode with `vrr_line_mode` high, `hold` stays low. At the last pixel of a blanking line (`v_pos` > `v_last`), a frame start seen during blanking loads (0, 0). Without such an event, the last pixel of line `v_total-1` loads (0, `v_total-1`) so that blanking lines repeat.
- R11: In variable-refresh mode, an event while `v_pos` <= `v_last` has no effect: no load and no change of `hold`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Video clock |
| rst | input | 1 | Synchronous active-high reset |
| fs_in | input | 1 | Asynchronous external frame-start signal |
| mode | input | 2 | 00 free-running, 01 frame lock, 10 variable refresh |
| soft_en | input | 1 | Soft lock instead of hard lock in lock mode |
| toggle_en | input | 1 | Treat both edges of fs_in as events |
| tol | input | CW (7) | Tolerance window in clock cycles |
| ign_lines | input | CW (7) | Lines to disregard frame start in soft lock |
| adj_lines | input | CW (7) | Total soft-lock lines, ignored lines included |
| h_target | input | HW (12) | Expected horizontal position of frame start |
| v_target | input | VW (12) | Expected vertical position of frame start |
| h_total | input | HW (12) | Pixels per line |
| v_total | input | VW (12) | Lines per frame |
| v_last | input | VW (12) | Index of the last active line |
| vrr_line_mode | input | 1 | Repeat blanking lines instead of stalling |
| h_pos | input | HW (12) | Current horizontal counter value |
| v_pos | input | VW (12) | Current vertical counter value |
| load_en | output | 1 | One-cycle counter load request |
| load_h | output | HW (12) | Horizontal load value |
| load_v | output | VW (12) | Vertical load value |
| hold | output | 1 | Freeze raster counters |
| line_adj | output | 2 | Per-line length change: 00 none, 01 +1, 11 -1 |

## Verification
Some rules are checked on every cycle. In pulse mode, events never fall on back-to-back cycles. Loads occur only in lock or variable-refresh mode, and a lock-mode load always carries the programmed target. The line correction changes only just after a line start and never takes its unused code. A stall is released only by a frame-start event or by leaving the stalling mode. Only the bench scenarios show the rest: the four-edge latency, the tolerance decisions on both sides of the window, the wrap at the frame boundary, the ignore window in soft lock, the number and sign of the adjust lines, and the two kinds of variable-refresh load.

// File: rtl/fl_pkg.sv
package fl_pkg;
  localparam logic [1:0] MODE_FREE = 2'b00;
  localparam logic [1:0] MODE_LOCK = 2'b01;
  localparam logic [1:0] MODE_VRR  = 2'b10;

  typedef logic [1:0] adj_t;
  localparam adj_t ADJ_NONE  = 2'b00;
  localparam adj_t ADJ_LONG  = 2'b01;
  localparam adj_t ADJ_SHORT = 2'b11;
endpackage

// File: rtl/fl_fs_edge.sv
module fl_fs_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic fs_async,
  input  logic toggle_en,
  output logic fs_evt
);
  logic [SYNC_STAGES-1:0] chain;
  logic                   last_q;
  logic                   edge_c;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain  <= '0;
      last_q <= 1'b0;
      fs_evt <= 1'b0;
    end else begin
      chain  <= {chain[SYNC_STAGES-2:0], fs_async};
      last_q <= chain[SYNC_STAGES-1];
      fs_evt <= edge_c;
    end
  end

  always_comb begin
    if (toggle_en) edge_c = chain[SYNC_STAGES-1] ^ last_q;
    else           edge_c = chain[SYNC_STAGES-1] & ~last_q;
  end

  // R1: in pulse mode two events can never sit on adjacent cycles
  assert_pulse_spacing_R1: assert property (@(posedge clk) disable iff (rst)
    (fs_evt && !toggle_en && !$past(toggle_en)) |=> !fs_evt);
endmodule

// File: rtl/fl_window.sv
module fl_window #(
  parameter int HW = 12,
  parameter int VW = 12,
  parameter int CW = 7
) (
  input  logic [HW-1:0]          h_pos,
  input  logic [VW-1:0]          v_pos,
  input  logic [HW-1:0]          h_target,
  input  logic [VW-1:0]          v_target,
  input  logic [HW-1:0]          h_total,
  input  logic [VW-1:0]          v_total,
  input  logic [CW-1:0]          tol,
  output logic signed [HW+VW+1:0] err,
  output logic                   in_win
);
  localparam int LW = HW + VW;
  localparam int EW = LW + 2;

  logic [LW-1:0]        lin, expv, frame;
  logic signed [EW-1:0] raw, half, fsz, wr;
  logic [EW-1:0]        mag;

  always_comb begin
    lin   = LW'(v_pos) * LW'(h_total) + LW'(h_pos);
    expv  = LW'(v_target) * LW'(h_total) + LW'(h_target);
    frame = LW'(v_total) * LW'(h_total);
    raw   = $signed({2'b00, lin}) - $signed({2'b00, expv});
    half  = $signed({3'b000, frame[LW-1:1]});
    fsz   = $signed({2'b00, frame});
    if (raw > half)       wr = raw - fsz;
    else if (raw < -half) wr = raw + fsz;
    else                  wr = raw;
    mag    = wr[EW-1] ? $unsigned(-wr) : $unsigned(wr);
    in_win = (mag <= {{(EW-CW){1'b0}}, tol});
    err    = wr;
  end
endmodule

// File: rtl/fl_soft_lock.sv
module fl_soft_lock
  import fl_pkg::*;
#(
  parameter int CW = 7,
  parameter int EW = 26
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 enable,
  input  logic                 start,
  input  logic signed [EW-1:0] err_in,
  input  logic                 line_start,
  input  logic [CW-1:0]        ign_lines,
  input  logic [CW-1:0]        adj_lines,
  output adj_t                 line_adj,
  output logic                 ignoring
);
  localparam logic signed [EW-1:0] ONE = 1;

  logic                 active;
  logic [CW-1:0]        cnt;
  logic signed [EW-1:0] rem;
  logic                 adj_line;

  assign adj_line = enable && active && !start && (cnt < adj_lines) &&
                    (cnt >= ign_lines) && (rem != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      active   <= 1'b0;
      cnt      <= '0;
      rem      <= '0;
      line_adj <= ADJ_NONE;
    end else begin
      if (line_start) begin
        if (adj_line) line_adj <= rem[EW-1] ? ADJ_SHORT : ADJ_LONG;
        else          line_adj <= ADJ_NONE;
      end
      if (!enable) begin
        active <= 1'b0;
      end else if (start) begin
        active <= 1'b1;
        cnt    <= '0;
        rem    <= err_in;
      end else if (line_start && active) begin
        if (cnt >= adj_lines) begin
          active <= 1'b0;
        end else begin
          cnt <= cnt + CW'(1);
          if (cnt >= ign_lines && rem != '0)
            rem <= rem[EW-1] ? rem + ONE : rem - ONE;
        end
      end
    end
  end

  assign ignoring = active && (ign_lines != '0) && (cnt <= ign_lines);

  // R8: the correction is held for a whole line
  assert_adj_line_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !line_start |=> $stable(line_adj));
  // R8: unused correction code never appears
  assert_adj_code_R8: assert property (@(posedge clk) disable iff (rst)
    line_adj != 2'b10);
endmodule

// File: rtl/fl_vrr.sv
module fl_vrr #(
  parameter int HW = 12,
  parameter int VW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          line_mode,
  input  logic          fs_evt,
  input  logic [HW-1:0] h_pos,
  input  logic [VW-1:0] v_pos,
  input  logic [HW-1:0] h_total,
  input  logic [VW-1:0] v_total,
  input  logic [VW-1:0] v_last,
  output logic          hold,
  output logic          ld_req,
  output logic [VW-1:0] ld_v
);
  localparam logic [HW-1:0] H_ONE = 1;
  localparam logic [VW-1:0] V_ONE = 1;

  logic line_end, frame_act_end, blank, end_q, le_q, le_rise, seen;

  assign line_end      = (h_pos == h_total - H_ONE);
  assign frame_act_end = line_end && (v_pos == v_last);
  assign blank         = (v_pos > v_last);
  assign le_rise       = line_end && !le_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      end_q <= 1'b0;
      le_q  <= 1'b0;
      hold  <= 1'b0;
      seen  <= 1'b0;
    end else begin
      end_q <= frame_act_end;
      le_q  <= line_end;
      if (!en) begin
        hold <= 1'b0;
        seen <= 1'b0;
      end else begin
        if (line_mode)                        hold <= 1'b0;
        else if (hold && fs_evt)              hold <= 1'b0;
        else if (frame_act_end && !end_q)     hold <= 1'b1;
        if (!line_mode)                       seen <= 1'b0;
        else if (fs_evt && blank)             seen <= 1'b1;
        else if (le_rise && blank && seen)    seen <= 1'b0;
      end
    end
  end

  assign ld_req = en && line_mode && le_rise && blank &&
                  (seen || (v_pos == v_total - V_ONE));
  assign ld_v   = seen ? '0 : v_total - V_ONE;

  // R9: a stall ends only on a frame-start event or on leaving stall mode
  assert_hold_release_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(hold) |-> ($past(fs_evt) || !$past(en) || $past(line_mode)));
  // R10: repeating-line mode never stalls
  assert_hold_stall_only_R10: assert property (@(posedge clk) disable iff (rst)
    hold |-> ($past(en) && !$past(line_mode)));
endmodule

// File: rtl/fl_frame_lock_ctrl.sv
module fl_frame_lock_ctrl
  import fl_pkg::*;
#(
  parameter int HW          = 12,
  parameter int VW          = 12,
  parameter int CW          = 7,
  parameter int SYNC_STAGES = 2,
  parameter bit SOFT_LOCK   = 1'b1,
  parameter bit VRR_SUPPORT = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fs_in,
  input  logic [1:0]    mode,
  input  logic          soft_en,
  input  logic          toggle_en,
  input  logic [CW-1:0] tol,
  input  logic [CW-1:0] ign_lines,
  input  logic [CW-1:0] adj_lines,
  input  logic [HW-1:0] h_target,
  input  logic [VW-1:0] v_target,
  input  logic [HW-1:0] h_total,
  input  logic [VW-1:0] v_total,
  input  logic [VW-1:0] v_last,
  input  logic          vrr_line_mode,
  input  logic [HW-1:0] h_pos,
  input  logic [VW-1:0] v_pos,
  output logic          load_en,
  output logic [HW-1:0] load_h,
  output logic [VW-1:0] load_v,
  output logic          hold,
  output logic [1:0]    line_adj
);
  localparam int EW = HW + VW + 2;

  logic                 fs_evt, in_win, ignoring, line_start;
  logic                 lock_on, soft_on, vrr_on, accepted, hard_ld, soft_start;
  logic                 vrr_ld;
  logic [VW-1:0]        vrr_ld_v;
  logic signed [EW-1:0] err;
  logic [HW-1:0]        h_prev;

  fl_fs_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst(rst), .fs_async(fs_in), .toggle_en(toggle_en), .fs_evt(fs_evt)
  );

  fl_window #(.HW(HW), .VW(VW), .CW(CW)) u_win (
    .h_pos(h_pos), .v_pos(v_pos), .h_target(h_target), .v_target(v_target),
    .h_total(h_total), .v_total(v_total), .tol(tol), .err(err), .in_win(in_win)
  );

  always_ff @(posedge clk) begin
    if (rst) h_prev <= '0;
    else     h_prev <= h_pos;
  end
  assign line_start = (h_pos == '0) && (h_prev != '0);

  assign lock_on    = (mode == MODE_LOCK);
  assign soft_on    = SOFT_LOCK && soft_en;
  assign vrr_on     = VRR_SUPPORT && (mode == MODE_VRR);
  assign accepted   = fs_evt && lock_on && !ignoring;
  assign hard_ld    = accepted && !in_win && !soft_on;
  assign soft_start = accepted && !in_win && soft_on;

  generate
    if (SOFT_LOCK) begin : g_soft
      fl_soft_lock #(.CW(CW), .EW(EW)) u_soft (
        .clk(clk), .rst(rst), .enable(lock_on && soft_on), .start(soft_start),
        .err_in(err), .line_start(line_start), .ign_lines(ign_lines),
        .adj_lines(adj_lines), .line_adj(line_adj), .ignoring(ignoring)
      );
    end else begin : g_nosoft
      assign line_adj = ADJ_NONE;
      assign ignoring = 1'b0;
    end

    if (VRR_SUPPORT) begin : g_vrr
      fl_vrr #(.HW(HW), .VW(VW)) u_vrr (
        .clk(clk), .rst(rst), .en(vrr_on), .line_mode(vrr_line_mode),
        .fs_evt(fs_evt), .h_pos(h_pos), .v_pos(v_pos), .h_total(h_total),
        .v_total(v_total), .v_last(v_last), .hold(hold), .ld_req(vrr_ld),
        .ld_v(vrr_ld_v)
      );
    end else begin : g_novrr
      assign hold     = 1'b0;
      assign vrr_ld   = 1'b0;
      assign vrr_ld_v = '0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      load_en <= 1'b0;
      load_h  <= '0;
      load_v  <= '0;
    end else begin
      load_en <= hard_ld || vrr_ld;
      load_h  <= hard_ld ? h_target : '0;
      load_v  <= hard_ld ? v_target : vrr_ld_v;
    end
  end

  // R3: no load request can follow a cycle spent free-running
  assert_no_free_load_R3: assert property (@(posedge clk) disable iff (rst)
    load_en |-> ($past(mode) == MODE_LOCK || $past(mode) == MODE_VRR));
  // R5: a lock-mode load always carries the programmed target
  assert_lock_target_R5: assert property (@(posedge clk) disable iff (rst)
    (load_en && $past(mode) == MODE_LOCK) |->
      (load_h == $past(h_target) && load_v == $past(v_target)));
endmodule

// File: tb/tb_fl_frame_lock_ctrl.sv
module tb_fl_frame_lock_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        fs_in = 1'b0;
  logic [1:0]  mode = 2'b00;
  logic        soft_en = 1'b0;
  logic        toggle_en = 1'b0;
  logic [6:0]  tol = 7'd0;
  logic [6:0]  ign_lines = 7'd0;
  logic [6:0]  adj_lines = 7'd0;
  logic [11:0] h_target = 12'd5;
  logic [11:0] v_target = 12'd2;
  logic [11:0] h_total = 12'd20;
  logic [11:0] v_total = 12'd10;
  logic [11:0] v_last = 12'd6;
  logic        vrr_line_mode = 1'b0;
  logic [11:0] h_pos = 12'd10;
  logic [11:0] v_pos = 12'd0;
  logic        load_en, hold;
  logic [11:0] load_h, load_v;
  logic [1:0]  line_adj;

  int n_chk = 0;
  int n_fail = 0;
  int ld_total = 0;
  logic [11:0] ld_h_cap = '0;
  logic [11:0] ld_v_cap = '0;

  always #4 clk = ~clk;

  fl_frame_lock_ctrl dut (
    .clk(clk), .rst(rst), .fs_in(fs_in), .mode(mode), .soft_en(soft_en),
    .toggle_en(toggle_en), .tol(tol), .ign_lines(ign_lines), .adj_lines(adj_lines),
    .h_target(h_target), .v_target(v_target), .h_total(h_total), .v_total(v_total),
    .v_last(v_last), .vrr_line_mode(vrr_line_mode), .h_pos(h_pos), .v_pos(v_pos),
    .load_en(load_en), .load_h(load_h), .load_v(load_v), .hold(hold),
    .line_adj(line_adj)
  );

  always @(negedge clk) begin
    if (load_en) begin
      ld_total <= ld_total + 1;
      ld_h_cap <= load_h;
      ld_v_cap <= load_v;
    end
  end

  typedef struct packed {
    logic [11:0] hr;
    logic [11:0] vr;
    logic [11:0] h;
    logic [11:0] v;
    logic [6:0]  tl;
    logic        exp_ld;
  } vec_t;

  localparam vec_t TBL [9] = '{
    '{12'd5, 12'd2, 12'd5,  12'd2, 7'd0,   1'b0},
    '{12'd5, 12'd2, 12'd8,  12'd2, 7'd3,   1'b0},
    '{12'd5, 12'd2, 12'd9,  12'd2, 7'd3,   1'b1},
    '{12'd5, 12'd2, 12'd2,  12'd2, 7'd3,   1'b0},
    '{12'd5, 12'd2, 12'd1,  12'd2, 7'd3,   1'b1},
    '{12'd5, 12'd2, 12'd5,  12'd3, 7'd3,   1'b1},
    '{12'd5, 12'd2, 12'd5,  12'd3, 7'd127, 1'b0},
    '{12'd1, 12'd0, 12'd18, 12'd9, 7'd3,   1'b0},
    '{12'd1, 12'd0, 12'd17, 12'd9, 7'd3,   1'b1}
  };

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic pulse_fs();
    fs_in = 1'b1;
    cyc(3);
    fs_in = 1'b0;
    cyc(6);
  endtask

  task automatic line_chk(input logic [1:0] expv, input logic [11:0] hback, input string tag);
    h_pos = 12'd0;
    cyc(1);
    h_pos = hback;
    chk(line_adj == expv, tag, int'(line_adj), int'(expv));
    cyc(1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk + 1, n_fail + 1);
    $finish;
  end

  initial begin
    int base;
    int seen_at;
    cyc(4);
    chk(load_en == 1'b0, "reset load_en", int'(load_en), 0);
    chk(hold == 1'b0, "reset hold", int'(hold), 0);
    chk(line_adj == 2'b00, "reset line_adj", int'(line_adj), 0);
    rst = 1'b0;
    cyc(3);

    // R4 R5 R6: tolerance window table in hard lock
    mode = 2'b01;
    for (int i = 0; i < 9; i++) begin
      h_target = TBL[i].hr; v_target = TBL[i].vr;
      h_pos = TBL[i].h; v_pos = TBL[i].v; tol = TBL[i].tl;
      cyc(2);
      base = ld_total;
      pulse_fs();
      chk(ld_total - base == int'(TBL[i].exp_ld), $sformatf("R4/R5 R6 vec %0d load count", i),
          ld_total - base, int'(TBL[i].exp_ld));
      if (TBL[i].exp_ld) begin
        chk(ld_h_cap == TBL[i].hr, "R5 load_h", int'(ld_h_cap), int'(TBL[i].hr));
        chk(ld_v_cap == TBL[i].vr, "R5 load_v", int'(ld_v_cap), int'(TBL[i].vr));
      end
    end

    // R1: latency and ignored falling edge in pulse mode
    h_target = 12'd5; v_target = 12'd2; h_pos = 12'd9; v_pos = 12'd2; tol = 7'd0;
    cyc(2);
    fs_in = 1'b1;
    seen_at = 0;
    for (int i = 1; i <= 6; i++) begin
      cyc(1);
      if (load_en && seen_at == 0) seen_at = i;
    end
    chk(seen_at == 4, "R1 load latency", seen_at, 4);
    base = ld_total;
    fs_in = 1'b0;
    cyc(8);
    chk(ld_total == base, "R1 falling edge ignored", ld_total - base, 0);

    // R2: toggle mode uses both edges
    toggle_en = 1'b1;
    base = ld_total;
    fs_in = 1'b1; cyc(8);
    chk(ld_total - base == 1, "R2 rising edge", ld_total - base, 1);
    fs_in = 1'b0; cyc(8);
    chk(ld_total - base == 2, "R2 falling edge", ld_total - base, 2);
    toggle_en = 1'b0;

    // R3: free-running ignores the input
    mode = 2'b00;
    base = ld_total;
    pulse_fs();
    chk(ld_total == base, "R3 no load", ld_total - base, 0);
    chk(hold == 1'b0, "R3 hold", int'(hold), 0);
    mode = 2'b11;
    pulse_fs();
    chk(ld_total == base, "R3 mode 11 no load", ld_total - base, 0);
    line_chk(2'b00, 12'd9, "R3 line_adj");

    // R7 R8: soft lock, raster ahead by 2
    mode = 2'b01; soft_en = 1'b1; tol = 7'd0; ign_lines = 7'd2; adj_lines = 7'd5;
    h_pos = 12'd7; v_pos = 12'd2;
    cyc(2);
    base = ld_total;
    pulse_fs();
    line_chk(2'b00, 12'd7, "R8 line0 ignored");
    h_pos = 12'd2;
    cyc(1);
    pulse_fs();
    line_chk(2'b00, 12'd7, "R8 line1 ignored");
    line_chk(2'b01, 12'd7, "R8 line2 lengthen");
    cyc(5);
    chk(line_adj == 2'b01, "R8 held through line", int'(line_adj), 1);
    line_chk(2'b01, 12'd7, "R8 line3 lengthen");
    line_chk(2'b00, 12'd7, "R8 line4 error consumed");
    line_chk(2'b00, 12'd7, "R8 line5 sequence over");
    chk(ld_total == base, "R7 soft lock never loads", ld_total - base, 0);

    // R8: raster behind by 2
    ign_lines = 7'd0; adj_lines = 7'd3;
    h_pos = 12'd3;
    cyc(2);
    pulse_fs();
    line_chk(2'b11, 12'd3, "R8 line0 shorten");
    line_chk(2'b11, 12'd3, "R8 line1 shorten");
    line_chk(2'b00, 12'd3, "R8 line2 done");
    soft_en = 1'b0;

    // R11 R9: variable refresh, stall variant
    mode = 2'b10; vrr_line_mode = 1'b0; v_last = 12'd6;
    h_pos = 12'd4; v_pos = 12'd3;
    cyc(2);
    base = ld_total;
    pulse_fs();
    chk(hold == 1'b0, "R11 active-line event", int'(hold), 0);
    chk(ld_total == base, "R11 no load", ld_total - base, 0);
    h_pos = 12'd19; v_pos = 12'd6;
    cyc(1);
    chk(hold == 1'b1, "R9 hold rises", int'(hold), 1);
    cyc(10);
    chk(hold == 1'b1, "R9 hold kept", int'(hold), 1);
    fs_in = 1'b1;
    cyc(3);
    chk(hold == 1'b1, "R9 hold before latency", int'(hold), 1);
    cyc(1);
    chk(hold == 1'b0, "R9 hold released", int'(hold), 0);
    fs_in = 1'b0;
    cyc(10);
    chk(hold == 1'b0, "R9 no re-stall", int'(hold), 0);
    chk(ld_total == base, "R9 no load", ld_total - base, 0);

    // R10: variable refresh, repeating blanking lines
    vrr_line_mode = 1'b1;
    h_pos = 12'd5; v_pos = 12'd9;
    cyc(2);
    base = ld_total;
    h_pos = 12'd19;
    cyc(3);
    chk(ld_total - base == 1, "R10 repeat load count", ld_total - base, 1);
    chk(ld_h_cap == 12'd0 && ld_v_cap == 12'd9, "R10 repeat target v", int'(ld_v_cap), 9);
    h_pos = 12'd5;
    cyc(1);
    pulse_fs();
    base = ld_total;
    h_pos = 12'd19;
    cyc(3);
    chk(ld_total - base == 1, "R10 restart load count", ld_total - base, 1);
    chk(ld_h_cap == 12'd0 && ld_v_cap == 12'd0, "R10 restart target v", int'(ld_v_cap), 0);
    chk(hold == 1'b0, "R10 no stall", int'(hold), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule